// File: doc/BRIEF.md
# Write-Only Two-Wire Register Receiver

This block is a slave receiver for an I2C-compatible two-wire bus. It takes write transfers to one fixed device address and fills two 16-bit output registers: a control word and a frequency word. The open-drain bus lines reach it as plain inputs, and a fast system clock samples them. The block answers each acknowledge slot through a single pull-down control output.

A transfer that the block accepts carries one or two byte pairs after the address. Each pair is a high byte followed by a low byte. The most significant bit of a pair's high byte selects which register the pair is for. A register changes only when both bytes of its pair have been taken in and acknowledged. At that point the new word appears together with a one-cycle update pulse.

The update pulses have no back-pressure, so a consumer must take a word in the cycle its pulse is high. The bus offers no way to slow the master, because this block does not stretch the clock. The block has no read mode and no high-speed mode.

Top module: `i2c_pair_receiver`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Bits are sampled on SCL rising edges, most significant bit first. An address byte of 0xCA (7-bit address 0x65, R/W bit 0) is acknowledged, and so is every following data byte up to the fourth.
- R2: An address byte other than 0xCA, including one with the R/W bit set, gets no acknowledge. The block then acknowledges nothing and updates nothing until the next START.
- R3: An acknowledge is a low level on `sda_pull_o`'s line: `sda_pull_o` rises after the SCL falling edge that ends bit 8 and falls after the SCL falling edge that ends the ninth bit. It is never high while a master data bit is on the bus.
- R4: A pair whose high byte has bit 7 = 1 is a control pair. `ctrl_q` becomes {high, low}, and `ctrl_upd` pulses for one cycle, after the low byte's acknowledge slot ends.
- R5: A pair whose high byte has bit 7 = 0 is a frequency pair. `freq_q` becomes {high, low}, and `freq_upd` pulses for one cycle, after the low byte's acknowledge slot ends.
- R6: In a four-byte transfer, the second pair updates the other register type in either order. A second pair of the same type as the first is acknowledged but changes nothing.
- R7: A fifth or later data byte in one transfer gets no acknowledge and changes no register.
- R8: A STOP or a repeated START after only the high byte of a pair drops that pair. A repeated START with address 0xCA begins a new transfer.
- R9: After reset, `ctrl_q` and `freq_q` are 0, both update pulses are low, and `sda_pull_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = drive the data line low (acknowledge) |
| ctrl_q | output | 16 | Control word, {high byte, low byte} |
| ctrl_upd | output | 1 | One-cycle pulse when `ctrl_q` takes a new word |
| freq_q | output | 16 | Frequency word, {high byte, low byte} |
| freq_upd | output | 1 | One-cycle pulse when `freq_q` takes a new word |

## Verification
The bench covers both pair orders and a same-type second pair. A design that latched on type alone would overwrite the first word with the second. It sends a fifth data byte, which a receiver with an off-by-one byte limit would acknowledge and possibly latch. It also sends a lone high byte cut off by STOP and then by a repeated START; a design that kept partial state would mix that stale byte into the next pair. Finally, it sends a wrong address followed by a data byte equal to the valid address, which a receiver that resumed listening too early would acknowledge. Throughout, the bench watches `sda_pull_o` during data bits to catch an acknowledge driven in the wrong slot.

// File: rtl/i2c_pair_pkg.sv
package i2c_pair_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef enum logic {
    PAIR_FREQ = 1'b0,
    PAIR_CTRL = 1'b1
  } pair_kind_t;
endpackage

// File: rtl/i2c_pair_line_sync.sv
module i2c_pair_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // A line event only counts while SCL stayed high across both samples.
  assign bus_start = scl_s & scl_d & sda_d & ~sda_s;
  assign bus_stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_pair_byte_engine.sv
module i2c_pair_byte_engine
  import i2c_pair_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              data_room,
  output logic              sda_pull_o,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [BYTE_W-1:0] WR_HDR = {ADDR7, 1'b0};

  logic              active, is_addr, in_ack, ack_given, pull_q, stb_q;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              accept;

  assign accept = is_addr ? (shreg == WR_HDR) : data_room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      is_addr   <= 1'b0;
      in_ack    <= 1'b0;
      ack_given <= 1'b0;
      pull_q    <= 1'b0;
      stb_q     <= 1'b0;
      cnt       <= '0;
      shreg     <= '0;
    end else begin
      stb_q <= 1'b0;
      if (bus_start) begin
        active    <= 1'b1;
        is_addr   <= 1'b1;
        in_ack    <= 1'b0;
        ack_given <= 1'b0;
        pull_q    <= 1'b0;
        cnt       <= '0;
      end else if (bus_stop) begin
        active <= 1'b0;
        in_ack <= 1'b0;
        pull_q <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        if (in_ack) begin
          if (scl_fall) begin
            in_ack <= 1'b0;
            pull_q <= 1'b0;
            cnt    <= '0;
            if (ack_given) begin
              if (is_addr) is_addr <= 1'b0;
              else         stb_q   <= 1'b1;
            end else if (is_addr) begin
              active <= 1'b0;
            end
          end
        end else if (cnt == FULL) begin
          if (scl_fall) begin
            in_ack    <= 1'b1;
            ack_given <= accept;
            pull_q    <= accept;
          end
        end else if (scl_rise) begin
          shreg <= {shreg[BYTE_W-2:0], sda_s};
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign byte_stb   = stb_q;
  assign byte_data  = shreg;

  p_ack_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(scl_fall));
  p_ack_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_q) |-> $past(scl_fall || bus_start || bus_stop));
  p_no_data_after_nack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(data_room || is_addr));
endmodule

// File: rtl/i2c_pair_assembler.sv
module i2c_pair_assembler
  import i2c_pair_pkg::*;
#(
  parameter int unsigned MAX_DATA = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              data_room,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              ctrl_upd,
  output logic [WORD_W-1:0] freq_q,
  output logic              freq_upd
);
  localparam int unsigned IDX_W = $clog2(MAX_DATA + 1);
  localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(MAX_DATA);

  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] hi_byte;
  pair_kind_t        cur_kind, first_kind, new_kind;
  logic              drop_pair;

  assign new_kind  = pair_kind_t'(byte_data[BYTE_W-1]);
  assign data_room = (idx < IDX_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      hi_byte    <= '0;
      cur_kind   <= PAIR_FREQ;
      first_kind <= PAIR_FREQ;
      drop_pair  <= 1'b0;
      ctrl_q     <= '0;
      freq_q     <= '0;
      ctrl_upd   <= 1'b0;
      freq_upd   <= 1'b0;
    end else begin
      ctrl_upd <= 1'b0;
      freq_upd <= 1'b0;
      if (bus_start || bus_stop) begin
        idx       <= '0;
        drop_pair <= 1'b0;
      end else if (byte_stb) begin
        idx <= idx + 1'b1;
        if (!idx[0]) begin
          hi_byte  <= byte_data;
          cur_kind <= new_kind;
          if (idx == '0) begin
            first_kind <= new_kind;
            drop_pair  <= 1'b0;
          end else begin
            drop_pair <= (new_kind == first_kind);
          end
        end else if (!drop_pair) begin
          if (cur_kind == PAIR_CTRL) begin
            ctrl_q   <= {hi_byte, byte_data};
            ctrl_upd <= 1'b1;
          end else begin
            freq_q   <= {hi_byte, byte_data};
            freq_upd <= 1'b1;
          end
        end
      end
    end
  end

  p_fifth_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> (idx < IDX_LIM));
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_upd, freq_upd}));
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_q) |-> ctrl_upd);
  p_freq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_q) |-> freq_upd);
endmodule

// File: rtl/i2c_pair_receiver.sv
module i2c_pair_receiver
  import i2c_pair_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR7   = 7'h65,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_DATA    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic [15:0] ctrl_q,
  output logic        ctrl_upd,
  output logic [15:0] freq_q,
  output logic        freq_upd
);
  logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic              data_room, byte_stb;
  logic [BYTE_W-1:0] byte_data;

  i2c_pair_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_pair_byte_engine #(.ADDR7(DEV_ADDR7)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
    .data_room(data_room), .sda_pull_o(sda_pull_o),
    .byte_stb(byte_stb), .byte_data(byte_data)
  );

  i2c_pair_assembler #(.MAX_DATA(MAX_DATA)) u_asm (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_stb(byte_stb), .byte_data(byte_data), .data_room(data_room),
    .ctrl_q(ctrl_q), .ctrl_upd(ctrl_upd), .freq_q(freq_q), .freq_upd(freq_upd)
  );
endmodule

// File: tb/i2c_pair_receiver_tb.sv
module i2c_pair_receiver_tb;
  localparam int Q  = 8;
  localparam int NV = 6;
  // bytes of each transfer, address first, left-aligned in 40 bits
  localparam int          NB [NV] = '{3, 3, 5, 5, 5, 2};
  localparam logic [39:0] BY [NV] = '{
    40'hCA85340000, 40'hCA12780000, 40'hCA9ABC4567,
    40'hCA3CC3F00F, 40'hCA81118222, 40'hCA7E000000};
  localparam int          EC [NV] = '{1, 0, 1, 1, 1, 0};
  localparam logic [15:0] VC [NV] = '{16'h8534, 16'h0, 16'h9ABC, 16'hF00F, 16'h8111, 16'h0};
  localparam int          EF [NV] = '{0, 1, 1, 1, 0, 0};
  localparam logic [15:0] VF [NV] = '{16'h0, 16'h1278, 16'h4567, 16'h3CC3, 16'h0, 16'h0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_o, ctrl_upd, freq_upd, sda_line;
  logic [15:0] ctrl_q, freq_q;
  int n_tests = 0, n_fail = 0;
  int cnt_ctrl = 0, cnt_freq = 0;
  logic bad_pull = 1'b0;
  logic [15:0] exp_ctrl = 16'h0, exp_freq = 16'h0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_o;

  i2c_pair_receiver u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .ctrl_q(ctrl_q), .ctrl_upd(ctrl_upd),
    .freq_q(freq_q), .freq_upd(freq_upd)
  );

  always @(negedge clk) begin
    if (ctrl_upd) cnt_ctrl++;
    if (freq_upd) cnt_freq++;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitq(int n);
    repeat (n * Q) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(1);
    scl_m = 1'b1; waitq(1);
    sda_m = 1'b0; waitq(1);
    scl_m = 1'b0; waitq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(1);
    scl_m = 1'b1; waitq(1);
    sda_m = 1'b1; waitq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitq(1);
      scl_m = 1'b1; waitq(1);
      @(negedge clk); if (sda_pull_o) bad_pull = 1'b1;
      waitq(1);
      scl_m = 1'b0; waitq(1);
    end
    sda_m = 1'b1; waitq(1);
    scl_m = 1'b1; waitq(1);
    @(negedge clk); ack = sda_line;
    waitq(1);
    scl_m = 1'b0; waitq(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [4:0] acks;
    int c0, f0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9 ctrl reset", ctrl_q, 0);
    check("R9 freq reset", freq_q, 0);
    check("R9 pull/strobes reset", {sda_pull_o, ctrl_upd, freq_upd}, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // table walk: R1 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      c0 = cnt_ctrl; f0 = cnt_freq; acks = '0; bad_pull = 1'b0;
      bus_start();
      for (int i = 0; i < NB[v]; i++) begin
        send_byte(BY[v][39 - 8*i -: 8], ack);
        acks[i] = ack;
      end
      bus_stop();
      waitq(2);
      if (EC[v] != 0) exp_ctrl = VC[v];
      if (EF[v] != 0) exp_freq = VF[v];
      check($sformatf("R1 acks vec%0d", v), acks, 0);
      check($sformatf("R3 no pull in data vec%0d", v), bad_pull, 0);
      check($sformatf("R4 ctrl pulses vec%0d", v), cnt_ctrl - c0, EC[v]);
      check($sformatf("R4 ctrl word vec%0d", v), ctrl_q, exp_ctrl);
      check($sformatf("R5 freq pulses vec%0d", v), cnt_freq - f0, EF[v]);
      check($sformatf("R5 freq word vec%0d", v), freq_q, exp_freq);
    end

    // R2: R/W bit set
    c0 = cnt_ctrl; f0 = cnt_freq; acks = '0;
    bus_start();
    send_byte(8'hCB, ack); acks[0] = ack;
    send_byte(8'h81, ack); acks[1] = ack;
    send_byte(8'h23, ack); acks[2] = ack;
    bus_stop(); waitq(2);
    check("R2 read bit nacked", acks[2:0], 3'b111);
    check("R2 read bit no update", (cnt_ctrl - c0) + (cnt_freq - f0), 0);

    // R2: wrong address, then a byte equal to the valid address
    c0 = cnt_ctrl; f0 = cnt_freq; acks = '0;
    bus_start();
    send_byte(8'hCC, ack); acks[0] = ack;
    send_byte(8'hCA, ack); acks[1] = ack;
    send_byte(8'h05, ack); acks[2] = ack;
    send_byte(8'h55, ack); acks[3] = ack;
    bus_stop(); waitq(2);
    check("R2 mismatch ignored", acks[3:0], 4'b1111);
    check("R2 mismatch no update", {ctrl_q, freq_q}, {exp_ctrl, exp_freq});

    // R7: fifth data byte
    c0 = cnt_ctrl; f0 = cnt_freq; acks = '0;
    bus_start();
    send_byte(8'hCA, ack); acks[0] = ack;
    send_byte(8'h81, ack); acks[1] = ack;
    send_byte(8'h00, ack); acks[2] = ack;
    send_byte(8'h02, ack); acks[3] = ack;
    send_byte(8'h00, ack); acks[4] = ack;
    send_byte(8'h55, ack);
    bus_stop(); waitq(2);
    exp_ctrl = 16'h8100; exp_freq = 16'h0200;
    check("R7 fifth byte nacked", ack, 1'b1);
    check("R7 first four acked", acks, 5'b0);
    check("R7 words unchanged by fifth", {ctrl_q, freq_q}, {exp_ctrl, exp_freq});
    check("R7 pulse count", (cnt_ctrl - c0) + (cnt_freq - f0), 2);

    // R8: lone high byte then STOP
    c0 = cnt_ctrl; f0 = cnt_freq;
    bus_start();
    send_byte(8'hCA, ack);
    send_byte(8'h9F, ack);
    bus_stop(); waitq(2);
    check("R8 stop drops half pair", (cnt_ctrl - c0) + (cnt_freq - f0), 0);

    // R8: lone high byte then repeated START, new frequency pair
    c0 = cnt_ctrl; f0 = cnt_freq;
    bus_start();
    send_byte(8'hCA, ack);
    send_byte(8'h80, ack);
    bus_start();
    send_byte(8'hCA, ack); acks[0] = ack;
    send_byte(8'h01, ack);
    send_byte(8'h23, ack);
    bus_stop(); waitq(2);
    exp_freq = 16'h0123;
    check("R8 restart acked", acks[0], 1'b0);
    check("R8 restart ctrl untouched", cnt_ctrl - c0, 0);
    check("R8 restart freq word", freq_q, exp_freq);
    check("R8 ctrl value kept", ctrl_q, exp_ctrl);
    check("R3 pull idle after stop", sda_pull_o, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule